// File: doc/BRIEF.md
# Temperature Alarm and Status Logic

This block watches every finished temperature conversion of a local channel and a remote channel and decides what the rest of the chip must be told about it. Each result is compared against a high limit, a low limit and a thermal-shutdown limit. The outcome is gathered into an 8-bit status byte, which mixes flags that latch until read with flags that follow the most recent conversion. The block also drives two active-low alarm pins: a thermal pin that software cannot disable and that releases with hysteresis, and an early-warning pin.

The early-warning pin has two modes. In alert mode it asserts only after a programmable run of out-of-limit conversions, or at once when the remote sensor is open, and it can be masked. It stays asserted until the block answers an alert-response request on the serial bus and wins the bit-wise address arbitration. In second-thermal mode the pin follows the high-limit comparisons with the same hysteresis as the thermal pin. The measurement itself, the serial bus engine and the register file lie outside the block; they deliver strobes, results and register values to it.

Temperatures are unsigned codes of `TW` bits with `FRAC` fractional bits (default 12 bits, 1/16 degree per step). The hysteresis value is given in whole degrees.

Top module: `temp_alarm_status`

## Requirements
- R1: After reset, every status bit except bit 7 reads 0, `alert_n` is 1, `therm_n` is 1, and `ara_ack` is 0.
- R2: The status bits sit at fixed positions: bit 7 busy, bit 6 local-high, bit 5 local-low, bit 4 remote-high, bit 3 remote-low, bit 2 open sensor, bit 1 remote-thermal, bit 0 local-thermal. Bit 7 mirrors `busy_in` in the same cycle.
- R3: A conversion whose result is greater than or equal to its high limit sets that channel's high bit. A result strictly below its low limit sets that channel's low bit. Each bit changes in the cycle after the strobe.
- R4: The two low bits and the open bit latch. The two high bits also latch while `cfg_therm2` is 0. A `stat_rd` pulse clears a latched bit only if the most recent conversion of its channel no longer shows the cause.
- R5: The thermal flag of a channel sets when a result reaches its thermal limit. It clears only when a result falls strictly below that limit minus `hyst_deg`·2^FRAC, and it is otherwise held. Status bits 1 and 0 show these flags directly.
- R6: `therm_n` is low exactly while either thermal flag is set. It ignores masking, mode and status reads.
- R7: The consecutive-count code `consec_code` gives a required run of (number of ones)+1 conversions: 000→1, 001→2, 011→3, 111→4. In alert mode the pin asserts only after that many consecutive out-of-limit conversions on one channel. An in-range conversion restarts the run. The code has no effect on the status bits.
- R8: `cfg_mask`=1 keeps `alert_n` high in alert mode, but the internal alert still latches. Clearing the mask exposes the latched alert at once.
- R9: With `cfg_therm2`=1, `alert_n` is low while either channel's high flag is set. The high flags use the high limits with the same hysteresis as R5. Status bits 6 and 4 then show these flags live, and `cfg_mask` has no effect.
- R10: A remote conversion with `rem_open`=1 sets the open bit and raises the alert at once. The remote comparisons are skipped for that conversion, so remote flags keep their previous values.
- R11: An `ara_req` pulse with `ara_addr`=7'b0001100 while `alert_n` is low in alert mode gives, in the next cycle, `ara_ack`=1 and `ara_byte`={DEV_ADDR, cause}. The cause bit is 1 if any high-limit trip occurred since the alert was last cleared, and 0 if only low-limit or open trips occurred. Any other request gives `ara_ack`=0.
- R12: The alert clears only when an acknowledged request wins arbitration. The block wins unless, at the first bit where it sends 1, the observed bus byte `ara_bus` shows 0. `ara_won` reports the outcome, and status reads never clear the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_in | input | 1 | Converter busy indication |
| loc_done | input | 1 | Local conversion finished strobe |
| loc_temp | input | TW | Local result |
| rem_done | input | 1 | Remote conversion finished strobe |
| rem_temp | input | TW | Remote result |
| rem_open | input | 1 | Remote sensor open during this conversion |
| loc_hi_lim | input | TW | Local high limit |
| loc_lo_lim | input | TW | Local low limit |
| rem_hi_lim | input | TW | Remote high limit |
| rem_lo_lim | input | TW | Remote low limit |
| loc_th_lim | input | TW | Local thermal limit |
| rem_th_lim | input | TW | Remote thermal limit |
| hyst_deg | input | HW | Thermal hysteresis, whole degrees |
| consec_code | input | MAX_CONSEC-1 | Consecutive-violation code |
| cfg_mask | input | 1 | Alert mask (configuration bit 7) |
| cfg_therm2 | input | 1 | Second-thermal mode (configuration bit 5) |
| stat_rd | input | 1 | Status byte read strobe |
| ara_req | input | 1 | Alert-response request strobe |
| ara_addr | input | 7 | Address of that request |
| ara_bus | input | 8 | Bus byte observed during the response |
| status | output | 8 | Status byte |
| alert_n | output | 1 | Early-warning / second-thermal pin, active low |
| therm_n | output | 1 | Thermal pin, active low |
| ara_ack | output | 1 | Request acknowledged |
| ara_byte | output | 8 | Returned address and cause bit |
| ara_won | output | 1 | Arbitration won, alert cleared |

## Verification
The assertions assume that strobes are single-cycle pulses and that the limits, hysteresis, code and mode bits stay constant while a conversion or request is in flight. They also assume that `ara_bus` is the wired-AND of the block's own byte with others, so it never shows a 1 where the block sends 0. The stimulus changes configuration only on idle cycles between strobes, and it offers bus bytes equal to the block's own byte or lower. Mode changes are made only after the alert state has been brought to a known value.

// File: rtl/tas_pkg.sv
package tas_pkg;
   // status byte bit positions
   localparam int ST_BUSY  = 7;
   localparam int ST_LHIGH = 6;
   localparam int ST_LLOW  = 5;
   localparam int ST_RHIGH = 4;
   localparam int ST_RLOW  = 3;
   localparam int ST_OPEN  = 2;
   localparam int ST_RTHRM = 1;
   localparam int ST_LTHRM = 0;

   localparam int N_CH = 2; // 0 = local, 1 = remote

   typedef struct packed {
      logic hi_ev;    // high limit reached on this conversion
      logic lo_ev;    // low limit crossed on this conversion
      logic cond_hi;  // last valid conversion was high
      logic cond_lo;  // last valid conversion was low
      logic trip;     // run length met on this conversion
      logic trip_hi;  // that trip was a high-limit trip
      logic therm;    // thermal flag with hysteresis
      logic hi2;      // high flag with hysteresis
   } chan_flags_t;
endpackage

// File: rtl/tas_hyst_flag.sv
module tas_hyst_flag #(
   parameter int TW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [TW-1:0] val,
   input  logic [TW-1:0] lim,
   input  logic [TW:0]   hyst,
   output logic          flag
);
   localparam int SW = TW + 2;

   logic [SW-1:0] sum;
   logic          set_c, rel_c;

   always_comb begin
      sum   = SW'(val) + SW'(hyst);
      set_c = val >= lim;
      rel_c = sum < SW'(lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (upd) begin
         if (set_c)
            flag <= 1'b1;
         else if (rel_c)
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/tas_channel.sv
module tas_channel #(
   parameter int TW        = 12,
   parameter int MAXC      = 4,
   parameter int CODE_W    = MAXC - 1,
   parameter int CNT_W     = $clog2(MAXC + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic                skip,
   input  logic [TW-1:0]       temp,
   input  logic [TW-1:0]       hi_lim,
   input  logic [TW-1:0]       lo_lim,
   input  logic [TW-1:0]       th_lim,
   input  logic [TW:0]         hyst,
   input  logic [CODE_W-1:0]   code,
   output tas_pkg::chan_flags_t flags
);
   logic             upd, over_hi, under_lo, viol;
   logic [CNT_W-1:0] cnt_q, cnt_inc, need;
   logic             cond_hi_q, cond_lo_q;
   logic             therm_f, hi2_f;

   always_comb begin
      upd      = done & ~skip;
      over_hi  = temp >= hi_lim;
      under_lo = temp < lo_lim;
      viol     = over_hi | under_lo;
      cnt_inc  = (cnt_q == CNT_W'(MAXC)) ? cnt_q : cnt_q + CNT_W'(1);
      need     = CNT_W'($countones(code)) + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cond_hi_q <= 1'b0;
         cond_lo_q <= 1'b0;
      end else if (upd) begin
         cnt_q     <= viol ? cnt_inc : '0;
         cond_hi_q <= over_hi;
         cond_lo_q <= under_lo;
      end
   end

   tas_hyst_flag #(.TW(TW)) u_therm (
      .clk(clk), .rst_n(rst_n), .upd(upd), .val(temp),
      .lim(th_lim), .hyst(hyst), .flag(therm_f));

   tas_hyst_flag #(.TW(TW)) u_hi2 (
      .clk(clk), .rst_n(rst_n), .upd(upd), .val(temp),
      .lim(hi_lim), .hyst(hyst), .flag(hi2_f));

   always_comb begin
      flags.hi_ev   = upd & over_hi;
      flags.lo_ev   = upd & under_lo;
      flags.cond_hi = cond_hi_q;
      flags.cond_lo = cond_lo_q;
      flags.trip    = upd & viol & (cnt_inc >= need);
      flags.trip_hi = upd & over_hi & (cnt_inc >= need);
      flags.therm   = therm_f;
      flags.hi2     = hi2_f;
   end
endmodule

// File: rtl/tas_ara_arb.sv
module tas_ara_arb #(
   parameter int BW = 8
) (
   input  logic [BW-1:0] own,
   input  logic [BW-1:0] bus,
   output logic          won
);
   // bit-serial arbitration unrolled MSB first: lose at the first bit
   // where a 1 is sent but a 0 is seen on the wire
   always_comb begin
      logic lost;
      lost = 1'b0;
      for (int i = BW - 1; i >= 0; i--) begin
         if (!lost && own[i] && !bus[i])
            lost = 1'b1;
      end
      won = ~lost;
   end
endmodule

// File: rtl/temp_alarm_status.sv
module temp_alarm_status #(
   parameter int          TW         = 12,
   parameter int          FRAC       = 4,
   parameter int          HW         = 8,
   parameter int          MAX_CONSEC = 4,
   parameter logic [6:0]  DEV_ADDR   = 7'h4C,
   parameter logic [6:0]  ARA_ADDR   = 7'h0C
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    busy_in,
   input  logic                    loc_done,
   input  logic [TW-1:0]           loc_temp,
   input  logic                    rem_done,
   input  logic [TW-1:0]           rem_temp,
   input  logic                    rem_open,
   input  logic [TW-1:0]           loc_hi_lim,
   input  logic [TW-1:0]           loc_lo_lim,
   input  logic [TW-1:0]           rem_hi_lim,
   input  logic [TW-1:0]           rem_lo_lim,
   input  logic [TW-1:0]           loc_th_lim,
   input  logic [TW-1:0]           rem_th_lim,
   input  logic [HW-1:0]           hyst_deg,
   input  logic [MAX_CONSEC-2:0]   consec_code,
   input  logic                    cfg_mask,
   input  logic                    cfg_therm2,
   input  logic                    stat_rd,
   input  logic                    ara_req,
   input  logic [6:0]              ara_addr,
   input  logic [7:0]              ara_bus,
   output logic [7:0]              status,
   output logic                    alert_n,
   output logic                    therm_n,
   output logic                    ara_ack,
   output logic [7:0]              ara_byte,
   output logic                    ara_won
);
   import tas_pkg::*;

   localparam int CODE_W = MAX_CONSEC - 1;
   localparam int N_STK  = 5; // latched status bits

   // elaboration-time parameter checks
   if (FRAC >= TW) begin : g_bad_frac
      $error("FRAC must be smaller than TW");
   end
   if (HW + FRAC > TW + 1) begin : g_bad_hyst
      $error("hysteresis does not fit the temperature width");
   end
   if (MAX_CONSEC < 2) begin : g_bad_consec
      $error("MAX_CONSEC must be at least 2");
   end

   logic [TW:0] hyst_full;
   assign hyst_full = (TW+1)'({hyst_deg, {FRAC{1'b0}}});

   chan_flags_t ch_f [N_CH];

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tas_channel #(.TW(TW), .MAXC(MAX_CONSEC), .CODE_W(CODE_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .done   ((c == 0) ? loc_done   : rem_done),
         .skip   ((c == 0) ? 1'b0       : rem_open),
         .temp   ((c == 0) ? loc_temp   : rem_temp),
         .hi_lim ((c == 0) ? loc_hi_lim : rem_hi_lim),
         .lo_lim ((c == 0) ? loc_lo_lim : rem_lo_lim),
         .th_lim ((c == 0) ? loc_th_lim : rem_th_lim),
         .hyst   (hyst_full),
         .code   (consec_code),
         .flags  (ch_f[c]));
   end

   // ---------------- latched status bits ----------------
   // order: {lhigh, llow, rhigh, rlow, open}
   logic             open_ev, open_cond_q;
   logic [N_STK-1:0] stk_q, stk_set, stk_cond;

   assign open_ev = rem_done & rem_open;

   always_comb begin
      stk_set  = {ch_f[0].hi_ev, ch_f[0].lo_ev, ch_f[1].hi_ev, ch_f[1].lo_ev, open_ev};
      stk_cond = {ch_f[0].cond_hi, ch_f[0].cond_lo, ch_f[1].cond_hi, ch_f[1].cond_lo,
                  open_cond_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stk_q       <= '0;
         open_cond_q <= 1'b0;
      end else begin
         stk_q <= stk_set | (stk_q & ~({N_STK{stat_rd}} & ~stk_cond));
         if (rem_done)
            open_cond_q <= rem_open;
      end
   end

   // ---------------- alert state and response ----------------
   logic       alert_q, cause_hi_q;
   logic       trip_any, trip_hi_any, pin_active, ara_hit, arb_won, clr;
   logic [7:0] own_byte;

   always_comb begin
      trip_any    = ch_f[0].trip | ch_f[1].trip | open_ev;
      trip_hi_any = ch_f[0].trip_hi | ch_f[1].trip_hi;
      pin_active  = alert_q & ~cfg_mask & ~cfg_therm2;
      own_byte    = {DEV_ADDR, cause_hi_q};
      ara_hit     = ara_req & (ara_addr == ARA_ADDR) & pin_active;
      clr         = ara_hit & arb_won;
   end

   tas_ara_arb #(.BW(8)) u_arb (.own(own_byte), .bus(ara_bus), .won(arb_won));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_q    <= 1'b0;
         cause_hi_q <= 1'b0;
         ara_ack    <= 1'b0;
         ara_byte   <= '0;
         ara_won    <= 1'b0;
      end else begin
         if (trip_any) begin
            alert_q    <= 1'b1;
            cause_hi_q <= (cause_hi_q & ~clr) | trip_hi_any;
         end else if (clr) begin
            alert_q    <= 1'b0;
            cause_hi_q <= 1'b0;
         end
         ara_ack  <= ara_hit;
         ara_byte <= ara_hit ? own_byte : 8'h00;
         ara_won  <= clr;
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      status           = '0;
      status[ST_BUSY]  = busy_in;
      status[ST_LHIGH] = cfg_therm2 ? ch_f[0].hi2 : stk_q[4];
      status[ST_LLOW]  = stk_q[3];
      status[ST_RHIGH] = cfg_therm2 ? ch_f[1].hi2 : stk_q[2];
      status[ST_RLOW]  = stk_q[1];
      status[ST_OPEN]  = stk_q[0];
      status[ST_RTHRM] = ch_f[1].therm;
      status[ST_LTHRM] = ch_f[0].therm;
      alert_n = cfg_therm2 ? ~(ch_f[0].hi2 | ch_f[1].hi2) : ~pin_active;
      therm_n = ~(ch_f[0].therm | ch_f[1].therm);
   end
endmodule

// File: rtl/tas_checker.sv
module tas_checker #(
   parameter logic [6:0] DEV_ADDR = 7'h4C
) (
   input logic       clk,
   input logic       rst_n,
   input logic       loc_done,
   input logic       rem_done,
   input logic       rem_open,
   input logic       cfg_mask,
   input logic       cfg_therm2,
   input logic       stat_rd,
   input logic       ara_req,
   input logic [7:0] status,
   input logic       alert_n,
   input logic       therm_n,
   input logic       ara_ack,
   input logic [7:0] ara_byte
);
   // latched low bit survives any cycle without a status read
   assert_llow_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[5] && !stat_rd) |=> status[5]);

   // thermal outputs only move on a conversion
   assert_therm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!loc_done && !rem_done) |=> ($stable(therm_n) && $stable(status[1:0])));

   // thermal pin agrees with the thermal status bits
   assert_therm_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      therm_n == !(status[1] || status[0]));

   // second-thermal mode follows the live high bits, mask ignored
   assert_therm2_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_therm2 |-> (alert_n == !(status[6] || status[4])));

   // open sensor conversion latches the open bit
   assert_open_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_done && rem_open) |=> status[2]);

   // acknowledge only follows a request and carries the device address
   assert_ack_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ara_ack |-> ($past(ara_req) && ara_byte[7:1] == DEV_ADDR));

   // in alert mode an asserted pin never releases without a request
   assert_alert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!alert_n && !cfg_therm2 && !cfg_mask && !ara_req)
         |=> (!alert_n || cfg_therm2 || cfg_mask));
endmodule

bind temp_alarm_status tas_checker #(.DEV_ADDR(DEV_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .loc_done(loc_done), .rem_done(rem_done),
   .rem_open(rem_open), .cfg_mask(cfg_mask), .cfg_therm2(cfg_therm2),
   .stat_rd(stat_rd), .ara_req(ara_req), .status(status), .alert_n(alert_n),
   .therm_n(therm_n), .ara_ack(ara_ack), .ara_byte(ara_byte));

// File: tb/temp_alarm_status_tb.sv
module temp_alarm_status_tb;
   localparam int TW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic busy_in = 1'b0;
   logic loc_done = 1'b0, rem_done = 1'b0, rem_open = 1'b0;
   logic [TW-1:0] loc_temp = '0, rem_temp = '0;
   logic [TW-1:0] loc_hi_lim = 12'h550, loc_lo_lim = 12'h0A0;
   logic [TW-1:0] rem_hi_lim = 12'h550, rem_lo_lim = 12'h0A0;
   logic [TW-1:0] loc_th_lim = 12'h640, rem_th_lim = 12'h640;
   logic [7:0] hyst_deg = 8'd10;
   logic [2:0] consec_code = 3'b000;
   logic cfg_mask = 1'b0, cfg_therm2 = 1'b0;
   logic stat_rd = 1'b0, ara_req = 1'b0;
   logic [6:0] ara_addr = '0;
   logic [7:0] ara_bus = '0;
   logic [7:0] status, ara_byte;
   logic alert_n, therm_n, ara_ack, ara_won;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   temp_alarm_status u_dut (
      .clk(clk), .rst_n(rst_n), .busy_in(busy_in),
      .loc_done(loc_done), .loc_temp(loc_temp),
      .rem_done(rem_done), .rem_temp(rem_temp), .rem_open(rem_open),
      .loc_hi_lim(loc_hi_lim), .loc_lo_lim(loc_lo_lim),
      .rem_hi_lim(rem_hi_lim), .rem_lo_lim(rem_lo_lim),
      .loc_th_lim(loc_th_lim), .rem_th_lim(rem_th_lim),
      .hyst_deg(hyst_deg), .consec_code(consec_code),
      .cfg_mask(cfg_mask), .cfg_therm2(cfg_therm2),
      .stat_rd(stat_rd), .ara_req(ara_req), .ara_addr(ara_addr), .ara_bus(ara_bus),
      .status(status), .alert_n(alert_n), .therm_n(therm_n),
      .ara_ack(ara_ack), .ara_byte(ara_byte), .ara_won(ara_won));

   // {loc[39:28], rem[27:16], open[15], read_after[14], status[13:6], alert_n[5], therm_n[4], pad}
   localparam int NV = 11;
   localparam logic [39:0] VEC [NV] = '{
      {12'h190, 12'h1E0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 4'h0},
      {12'h5A0, 12'h1E0, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1, 4'h0},
      {12'h190, 12'h050, 1'b0, 1'b1, 8'h48, 1'b0, 1'b1, 4'h0},
      {12'h190, 12'h1E0, 1'b0, 1'b1, 8'h08, 1'b0, 1'b1, 4'h0},
      {12'h650, 12'h1E0, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0, 4'h0},
      {12'h5F0, 12'h1E0, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0, 4'h0},
      {12'h590, 12'h1E0, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1, 4'h0},
      {12'h190, 12'h000, 1'b1, 1'b1, 8'h44, 1'b0, 1'b1, 4'h0},
      {12'h190, 12'h1E0, 1'b0, 1'b1, 8'h04, 1'b0, 1'b1, 4'h0},
      {12'h190, 12'h650, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 4'h0},
      {12'h190, 12'h1E0, 1'b0, 1'b1, 8'h10, 1'b0, 1'b1, 4'h0}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic conv(input logic [TW-1:0] lt, input logic [TW-1:0] rt, input logic op);
      @(negedge clk);
      loc_temp = lt; rem_temp = rt; rem_open = op;
      loc_done = 1'b1; rem_done = 1'b1;
      @(negedge clk);
      loc_done = 1'b0; rem_done = 1'b0; rem_open = 1'b0;
   endtask

   task automatic rd();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic ara(input logic [6:0] a, input logic [7:0] b);
      @(negedge clk);
      ara_req = 1'b1; ara_addr = a; ara_bus = b;
      @(negedge clk);
      ara_req = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 8'h00);
      chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
      chk("R1 therm_n", {7'd0, therm_n}, 8'h01);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ara_ack", {7'd0, ara_ack}, 8'h00);

      // table walk: R3 compares, R4 sticky clearing, R5 hysteresis, R6 pin, R10 open
      for (int i = 0; i < NV; i++) begin
         conv(VEC[i][39:28], VEC[i][27:16], VEC[i][15]);
         chk($sformatf("R3/R4/R5 status vec%0d", i), status, VEC[i][13:6]);
         chk($sformatf("R7 alert_n vec%0d", i), {7'd0, alert_n}, {7'd0, VEC[i][5]});
         chk($sformatf("R6 therm_n vec%0d", i), {7'd0, therm_n}, {7'd0, VEC[i][4]});
         if (VEC[i][14]) rd();
      end
      chk("R4 status cleared after table", status, 8'h00);

      // R11/R12 won response, cause high
      ara(7'h0C, 8'h99);
      chk("R11 ack", {7'd0, ara_ack}, 8'h01);
      chk("R11 byte hi", ara_byte, 8'h99);
      chk("R12 won", {7'd0, ara_won}, 8'h01);
      chk("R12 alert released", {7'd0, alert_n}, 8'h01);
      ara(7'h0C, 8'hFF);
      chk("R11 no ack when idle", {7'd0, ara_ack}, 8'h00);

      // low cause, wrong address, read does not clear, lost arbitration
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R3 llow", status, 8'h20);
      ara(7'h0D, 8'h98);
      chk("R11 wrong addr", {7'd0, ara_ack}, 8'h00);
      rd();
      chk("R4 llow kept while low", status, 8'h20);
      chk("R12 read keeps alert", {7'd0, alert_n}, 8'h00);
      ara(7'h0C, 8'h90);
      chk("R11 byte lo", ara_byte, 8'h98);
      chk("R12 lost", {7'd0, ara_won}, 8'h00);
      chk("R12 alert kept on loss", {7'd0, alert_n}, 8'h00);
      ara(7'h0C, 8'h98);
      chk("R12 won lo", {7'd0, alert_n}, 8'h01);

      // R7 consecutive count, code 011 -> 3
      consec_code = 3'b011;
      conv(12'h190, 12'h1E0, 1'b0);
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R7 status unaffected by count", status[5], 1'b1);
      chk("R7 run1", {7'd0, alert_n}, 8'h01);
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R7 run2", {7'd0, alert_n}, 8'h01);
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R7 run3 asserts", {7'd0, alert_n}, 8'h00);
      ara(7'h0C, 8'h98);
      conv(12'h190, 12'h1E0, 1'b0);
      conv(12'h050, 12'h1E0, 1'b0);
      conv(12'h050, 12'h1E0, 1'b0);
      conv(12'h190, 12'h1E0, 1'b0);
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R7 broken run stays high", {7'd0, alert_n}, 8'h01);
      conv(12'h190, 12'h1E0, 1'b0);
      rd();
      chk("R4 cleared", status, 8'h00);
      consec_code = 3'b000;

      // R8 mask
      @(negedge clk); cfg_mask = 1'b1;
      conv(12'h050, 12'h1E0, 1'b0);
      chk("R8 masked pin", {7'd0, alert_n}, 8'h01);
      ara(7'h0C, 8'h98);
      chk("R8 masked no ack", {7'd0, ara_ack}, 8'h00);
      @(negedge clk); cfg_mask = 1'b0; #1;
      chk("R8 unmask exposes", {7'd0, alert_n}, 8'h00);
      ara(7'h0C, 8'h98);
      conv(12'h190, 12'h1E0, 1'b0);
      rd();

      // R9 second-thermal mode
      @(negedge clk); cfg_therm2 = 1'b1;
      conv(12'h560, 12'h1E0, 1'b0);
      chk("R9 asserts", {7'd0, alert_n}, 8'h00);
      chk("R9 live high", status, 8'h40);
      conv(12'h500, 12'h1E0, 1'b0);
      chk("R9 hyst hold", {7'd0, alert_n}, 8'h00);
      conv(12'h4A0, 12'h1E0, 1'b0);
      chk("R9 release", {7'd0, alert_n}, 8'h01);
      chk("R9 live high cleared", status, 8'h00);
      @(negedge clk); cfg_mask = 1'b1;
      conv(12'h560, 12'h1E0, 1'b0);
      chk("R9 mask ignored", {7'd0, alert_n}, 8'h00);
      conv(12'h190, 12'h1E0, 1'b0);
      @(negedge clk); cfg_mask = 1'b0; cfg_therm2 = 1'b0; #1;
      chk("R4 latched high back in alert mode", status, 8'h40);
      chk("R8 internal alert kept", {7'd0, alert_n}, 8'h00);
      rd();
      ara(7'h0C, 8'h99);
      chk("R11 cause from therm2 period", ara_byte, 8'h99);

      // R5 boundaries
      conv(12'h640, 12'h1E0, 1'b0);
      chk("R5 reach sets", {7'd0, therm_n}, 8'h00);
      conv(12'h5A0, 12'h1E0, 1'b0);
      chk("R5 equal to release point holds", {7'd0, therm_n}, 8'h00);
      conv(12'h59F, 12'h1E0, 1'b0);
      chk("R5 below releases", {7'd0, therm_n}, 8'h01);
      chk("R5 bit0 cleared", {7'd0, status[0]}, 8'h00);

      // R10 open sensor
      ara(7'h0C, 8'h99);
      conv(12'h190, 12'h650, 1'b1);
      chk("R10 alert", {7'd0, alert_n}, 8'h00);
      chk("R10 remote skipped", {7'd0, therm_n}, 8'h01);
      chk("R10 open bits", {6'd0, status[2:1]}, 8'h02);
      ara(7'h0C, 8'h98);
      chk("R11 open cause low", ara_byte, 8'h98);

      // R2 busy mirror
      @(negedge clk); busy_in = 1'b1; #1;
      chk("R2 busy", {7'd0, status[7]}, 8'h01);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule